// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block turns the opcode field (instruction bits 31:26) and the function field (bits 5:0) of a 32-bit load/store instruction word into every control line a single-cycle datapath needs. It is purely combinational. The outputs settle in the same cycle as the instruction word, and the surrounding datapath registers them where it needs to.

The decoder works in two stages. The first stage sorts the instruction into one of eleven named kinds and picks its ALU code. The kinds are: register ALU, immediate ALU, load, store, branch-if-equal, branch-if-not-equal, absolute jump, absolute jump with link, register jump, register jump with link, and unrecognised. The second stage derives the multiplexer selects and the next-PC class from that kind alone. There is no state and there are no transitions.

The register file, the ALU, the memories and the next-PC adders stay outside this block. The decoder only tells them what to do. Any encoding it does not recognise yields safe defaults: sequential next-PC, no register write and no memory write.

Top module: `ctl_decoder`

## Requirements
- R1: The ALU code is 000 for AND, 001 for OR, 010 for SLT, 011 for ADD and 100 for SUB. For opcode 0x00, the function field selects the code: 0x24 gives AND, 0x25 gives OR, 0x2A gives SLT, 0x20 gives ADD and 0x22 gives SUB.
- R2: The ALU code follows the opcode as follows. Opcode 0x06 gives AND, 0x0D gives OR, 0x0A gives SLT and 0x08 gives ADD. Opcodes 0x23, 0x20, 0x2B and 0x28 give ADD. Opcodes 0x04 and 0x05 give SUB. Opcodes 0x02 and 0x03, and function codes 0x08 and 0x09 under opcode 0x00, give ADD.
- R3: `src_imm_o` is 1 for opcodes 0x06, 0x0D, 0x0A, 0x08, 0x23, 0x20, 0x2B and 0x28, and 0 otherwise.
- R4: `wb_mem_o` is 1 only for opcodes 0x23 and 0x20.
- R5: `dst_rt_o` is 1 only for opcodes 0x06, 0x0D, 0x0A, 0x08, 0x23 and 0x20.
- R6: `dst_link_o` is 1 only for opcode 0x03.
- R7: `wb_ret_o` is 1 only for opcode 0x03, and for opcode 0x00 with function 0x09.
- R8: `npc_class_o` takes these values:
  - 00 for opcodes 0x04 and 0x05.
  - 01 for opcodes 0x02 and 0x03.
  - 10 for opcode 0x00 with function 0x08 or 0x09.
  - 11 for every other encoding.
- R9: `br_inv_o` is 1 only for opcode 0x05. It is 0 for opcode 0x04, and 0 otherwise.
- R10: `mem_wr_o` is 1 only for opcodes 0x2B and 0x28.
- R11: `reg_we_o` is 1 for these encodings, and 0 for all others:
  - opcode 0x00 with function 0x24, 0x25, 0x2A, 0x20, 0x22 or 0x09;
  - opcodes 0x06, 0x0D, 0x0A, 0x08, 0x23, 0x20 and 0x03.
- R12: An unrecognised encoding drives a fixed set of defaults. This covers any other opcode, and any other function code under opcode 0x00. The defaults are: ALU code 011, `npc_class_o` 11, and 0 on every single-bit output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Opcode field, instruction bits 31:26 |
| fn_i | input | 6 | Function field, instruction bits 5:0 |
| alu_code_o | output | 3 | ALU operation code |
| src_imm_o | output | 1 | ALU second operand: 1 = sign-extended immediate, 0 = rt value |
| wb_mem_o | output | 1 | Writeback source: 1 = memory read data, 0 = ALU result |
| dst_rt_o | output | 1 | Destination field: 1 = bits 20:16, 0 = bits 15:11 |
| dst_link_o | output | 1 | Force destination register 31 |
| wb_ret_o | output | 1 | Write the return address instead of the data result |
| npc_class_o | output | 2 | Next-PC class: 00 branch, 01 absolute jump, 10 register jump, 11 sequential |
| br_inv_o | output | 1 | Branch polarity: 1 = use the inverted ALU zero flag |
| mem_wr_o | output | 1 | Data memory direction: 1 = write, 0 = read |
| reg_we_o | output | 1 | Register file write enable |

## Verification
The bench builds the decoder with its default field widths of six opcode bits and six function bits. At those widths the input space is only 4096 pairs, so the bench sweeps every opcode against every function code. Every listed instruction, every unused function code under opcode 0x00, and every unused opcode is therefore compared output by output against a table the bench derives on its own. This also shows that the function field is ignored outside opcode 0x00.

// File: rtl/ctl_dec_pkg.sv
package ctl_dec_pkg;

    localparam int OP_W  = 6;
    localparam int FN_W  = 6;
    localparam int ALU_W = 3;
    localparam int NPC_W = 2;

    typedef enum logic [ALU_W-1:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_SLT = 3'b010,
        ALU_ADD = 3'b011,
        ALU_SUB = 3'b100
    } alu_code_e;

    typedef enum logic [NPC_W-1:0] {
        NPC_BRANCH = 2'b00,
        NPC_ABS    = 2'b01,
        NPC_REG    = 2'b10,
        NPC_SEQ    = 2'b11
    } npc_class_e;

    typedef enum logic [3:0] {
        KIND_REG_ALU,
        KIND_IMM_ALU,
        KIND_LOAD,
        KIND_STORE,
        KIND_BR_EQ,
        KIND_BR_NE,
        KIND_JMP,
        KIND_JMP_LINK,
        KIND_JREG,
        KIND_JREG_LINK,
        KIND_BAD
    } insn_kind_e;

    localparam logic [OP_W-1:0] OPC_SPECIAL = 6'h00;
    localparam logic [OP_W-1:0] OPC_JMP     = 6'h02;
    localparam logic [OP_W-1:0] OPC_JLINK   = 6'h03;
    localparam logic [OP_W-1:0] OPC_BEQ     = 6'h04;
    localparam logic [OP_W-1:0] OPC_BNE     = 6'h05;
    localparam logic [OP_W-1:0] OPC_ANDI    = 6'h06;
    localparam logic [OP_W-1:0] OPC_ADDI    = 6'h08;
    localparam logic [OP_W-1:0] OPC_SLTI    = 6'h0A;
    localparam logic [OP_W-1:0] OPC_ORI     = 6'h0D;
    localparam logic [OP_W-1:0] OPC_LDB     = 6'h20;
    localparam logic [OP_W-1:0] OPC_LDW     = 6'h23;
    localparam logic [OP_W-1:0] OPC_STB     = 6'h28;
    localparam logic [OP_W-1:0] OPC_STW     = 6'h2B;

    localparam logic [FN_W-1:0] FN_JREG     = 6'h08;
    localparam logic [FN_W-1:0] FN_JRLINK   = 6'h09;
    localparam logic [FN_W-1:0] FN_ADD      = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB      = 6'h22;
    localparam logic [FN_W-1:0] FN_AND      = 6'h24;
    localparam logic [FN_W-1:0] FN_OR       = 6'h25;
    localparam logic [FN_W-1:0] FN_SLT      = 6'h2A;

endpackage

// File: rtl/ctl_classify.sv
module ctl_classify
    import ctl_dec_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    input  logic [FN_W-1:0] fn_i,
    output insn_kind_e      kind_o,
    output alu_code_e       alu_o
);

    insn_kind_e kind_q;
    alu_code_e  alu_q;

    always_comb begin
        kind_q = KIND_BAD;
        alu_q  = ALU_ADD;
        unique case (op_i)
            OPC_SPECIAL: begin
                unique case (fn_i)
                    FN_AND:    begin kind_q = KIND_REG_ALU;   alu_q = ALU_AND; end
                    FN_OR:     begin kind_q = KIND_REG_ALU;   alu_q = ALU_OR;  end
                    FN_SLT:    begin kind_q = KIND_REG_ALU;   alu_q = ALU_SLT; end
                    FN_ADD:    begin kind_q = KIND_REG_ALU;   alu_q = ALU_ADD; end
                    FN_SUB:    begin kind_q = KIND_REG_ALU;   alu_q = ALU_SUB; end
                    FN_JREG:   begin kind_q = KIND_JREG;      alu_q = ALU_ADD; end
                    FN_JRLINK: begin kind_q = KIND_JREG_LINK; alu_q = ALU_ADD; end
                    default:   begin kind_q = KIND_BAD;       alu_q = ALU_ADD; end
                endcase
            end
            OPC_ANDI:  begin kind_q = KIND_IMM_ALU;  alu_q = ALU_AND; end
            OPC_ORI:   begin kind_q = KIND_IMM_ALU;  alu_q = ALU_OR;  end
            OPC_SLTI:  begin kind_q = KIND_IMM_ALU;  alu_q = ALU_SLT; end
            OPC_ADDI:  begin kind_q = KIND_IMM_ALU;  alu_q = ALU_ADD; end
            OPC_LDW,
            OPC_LDB:   begin kind_q = KIND_LOAD;     alu_q = ALU_ADD; end
            OPC_STW,
            OPC_STB:   begin kind_q = KIND_STORE;    alu_q = ALU_ADD; end
            OPC_BEQ:   begin kind_q = KIND_BR_EQ;    alu_q = ALU_SUB; end
            OPC_BNE:   begin kind_q = KIND_BR_NE;    alu_q = ALU_SUB; end
            OPC_JMP:   begin kind_q = KIND_JMP;      alu_q = ALU_ADD; end
            OPC_JLINK: begin kind_q = KIND_JMP_LINK; alu_q = ALU_ADD; end
            default:   begin kind_q = KIND_BAD;      alu_q = ALU_ADD; end
        endcase
    end

    assign kind_o = kind_q;
    assign alu_o  = alu_q;

    always_comb begin
        AST_BRANCH_SUB: assert (!(kind_q inside {KIND_BR_EQ, KIND_BR_NE}) || alu_q == ALU_SUB); // R2
        AST_BAD_ADD: assert (kind_q != KIND_BAD || alu_q == ALU_ADD); // R12
    end

endmodule

// File: rtl/ctl_select.sv
module ctl_select
    import ctl_dec_pkg::*;
(
    input  insn_kind_e kind_i,
    output logic       src_imm_o,
    output logic       wb_mem_o,
    output logic       dst_rt_o,
    output logic       dst_link_o,
    output logic       wb_ret_o,
    output logic       mem_wr_o,
    output logic       reg_we_o
);

    always_comb begin
        src_imm_o  = 1'b0;
        wb_mem_o   = 1'b0;
        dst_rt_o   = 1'b0;
        dst_link_o = 1'b0;
        wb_ret_o   = 1'b0;
        mem_wr_o   = 1'b0;
        reg_we_o   = 1'b0;
        unique case (kind_i)
            KIND_REG_ALU: begin
                reg_we_o = 1'b1;
            end
            KIND_IMM_ALU: begin
                src_imm_o = 1'b1;
                dst_rt_o  = 1'b1;
                reg_we_o  = 1'b1;
            end
            KIND_LOAD: begin
                src_imm_o = 1'b1;
                wb_mem_o  = 1'b1;
                dst_rt_o  = 1'b1;
                reg_we_o  = 1'b1;
            end
            KIND_STORE: begin
                src_imm_o = 1'b1;
                mem_wr_o  = 1'b1;
            end
            KIND_JMP_LINK: begin
                dst_link_o = 1'b1;
                wb_ret_o   = 1'b1;
                reg_we_o   = 1'b1;
            end
            KIND_JREG_LINK: begin
                wb_ret_o = 1'b1;
                reg_we_o = 1'b1;
            end
            KIND_BR_EQ, KIND_BR_NE, KIND_JMP, KIND_JREG, KIND_BAD: begin
            end
            default: begin
            end
        endcase
    end

    always_comb begin
        AST_STORE_NO_WE: assert (!mem_wr_o || !reg_we_o); // R10
        AST_LOAD_IMM: assert (!wb_mem_o || (src_imm_o && dst_rt_o)); // R4
        AST_LINK_RET: assert (!dst_link_o || wb_ret_o); // R6
    end

endmodule

// File: rtl/ctl_flow.sv
module ctl_flow
    import ctl_dec_pkg::*;
(
    input  insn_kind_e kind_i,
    output npc_class_e npc_o,
    output logic       br_inv_o
);

    always_comb begin
        npc_o    = NPC_SEQ;
        br_inv_o = 1'b0;
        unique case (kind_i)
            KIND_BR_EQ:     npc_o = NPC_BRANCH;
            KIND_BR_NE: begin
                npc_o    = NPC_BRANCH;
                br_inv_o = 1'b1;
            end
            KIND_JMP,
            KIND_JMP_LINK:  npc_o = NPC_ABS;
            KIND_JREG,
            KIND_JREG_LINK: npc_o = NPC_REG;
            default:        npc_o = NPC_SEQ;
        endcase
    end

    always_comb begin
        AST_INV_BRANCH: assert (!br_inv_o || npc_o == NPC_BRANCH); // R9
    end

endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
    import ctl_dec_pkg::*;
(
    input  logic [OP_W-1:0]  op_i,
    input  logic [FN_W-1:0]  fn_i,
    output logic [ALU_W-1:0] alu_code_o,
    output logic             src_imm_o,
    output logic             wb_mem_o,
    output logic             dst_rt_o,
    output logic             dst_link_o,
    output logic             wb_ret_o,
    output logic [NPC_W-1:0] npc_class_o,
    output logic             br_inv_o,
    output logic             mem_wr_o,
    output logic             reg_we_o
);

    insn_kind_e kind;
    alu_code_e  alu;
    npc_class_e npc;

    ctl_classify u_classify (
        .op_i   (op_i),
        .fn_i   (fn_i),
        .kind_o (kind),
        .alu_o  (alu)
    );

    ctl_select u_select (
        .kind_i     (kind),
        .src_imm_o  (src_imm_o),
        .wb_mem_o   (wb_mem_o),
        .dst_rt_o   (dst_rt_o),
        .dst_link_o (dst_link_o),
        .wb_ret_o   (wb_ret_o),
        .mem_wr_o   (mem_wr_o),
        .reg_we_o   (reg_we_o)
    );

    ctl_flow u_flow (
        .kind_i   (kind),
        .npc_o    (npc),
        .br_inv_o (br_inv_o)
    );

    assign alu_code_o  = alu;
    assign npc_class_o = npc;

    always_comb begin
        AST_RET_IS_JUMP: assert (!wb_ret_o || npc_class_o == 2'b01 || npc_class_o == 2'b10); // R7
        AST_BRANCH_NO_WE: assert (npc_class_o != 2'b00 || (!reg_we_o && !mem_wr_o)); // R8
        AST_MEMWR_IMM: assert (!mem_wr_o || src_imm_o); // R3
    end

endmodule

// File: tb/ctl_decoder_test.sv
module ctl_decoder_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] op;
    logic [5:0] fn;
    logic [2:0] alu_code;
    logic       src_imm, wb_mem, dst_rt, dst_link, wb_ret, br_inv, mem_wr, reg_we;
    logic [1:0] npc_class;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ctl_decoder uut (
        .op_i        (op),
        .fn_i        (fn),
        .alu_code_o  (alu_code),
        .src_imm_o   (src_imm),
        .wb_mem_o    (wb_mem),
        .dst_rt_o    (dst_rt),
        .dst_link_o  (dst_link),
        .wb_ret_o    (wb_ret),
        .npc_class_o (npc_class),
        .br_inv_o    (br_inv),
        .mem_wr_o    (mem_wr),
        .reg_we_o    (reg_we)
    );

    task automatic chk(input string req, input int act, input int exp, input int o, input int f);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s op=%02h fn=%02h actual=%0d expected=%0d", req, o, f, act, exp);
        end
    endtask

    initial begin
        op = 6'h3F;
        fn = 6'h3F;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset-time state: unused opcode 0x3F drives defaults (R12)
        chk("R12 reset alu", int'(alu_code), 3, 63, 63);
        chk("R12 reset npc", int'(npc_class), 3, 63, 63);
        chk("R12 reset we", int'(reg_we), 0, 63, 63);
        chk("R12 reset wr", int'(mem_wr), 0, 63, 63);
        rst = 1'b0;
        for (int o = 0; o < 64; o++) begin
            for (int f = 0; f < 64; f++) begin
                bit rt_alu, rt_jr, rt_jrl, imm_alu, ld, st, beq, bne, jmp, jal, known;
                int e_alu, e_npc;
                @(posedge clk);
                op = 6'(o);
                fn = 6'(f);
                @(negedge clk);
                rt_alu  = (o == 0) && (f == 'h24 || f == 'h25 || f == 'h2A || f == 'h20 || f == 'h22);
                rt_jr   = (o == 0) && (f == 'h08);
                rt_jrl  = (o == 0) && (f == 'h09);
                imm_alu = (o == 'h06 || o == 'h0D || o == 'h0A || o == 'h08);
                ld      = (o == 'h23 || o == 'h20);
                st      = (o == 'h2B || o == 'h28);
                beq     = (o == 'h04);
                bne     = (o == 'h05);
                jmp     = (o == 'h02);
                jal     = (o == 'h03);
                known   = rt_alu | rt_jr | rt_jrl | imm_alu | ld | st | beq | bne | jmp | jal;
                e_alu = 3;
                if (o == 0 && f == 'h24 || o == 'h06) e_alu = 0;
                if (o == 0 && f == 'h25 || o == 'h0D) e_alu = 1;
                if (o == 0 && f == 'h2A || o == 'h0A) e_alu = 2;
                if (o == 0 && f == 'h22 || beq || bne) e_alu = 4;
                e_npc = 3;
                if (beq || bne) e_npc = 0;
                if (jmp || jal) e_npc = 1;
                if (rt_jr || rt_jrl) e_npc = 2;
                if (!known) begin
                    // R12: unrecognised encodings give safe defaults
                    chk("R12 alu", int'(alu_code), 3, o, f);
                    chk("R12 npc", int'(npc_class), 3, o, f);
                    chk("R12 bits", int'({src_imm, wb_mem, dst_rt, dst_link, wb_ret, br_inv, mem_wr, reg_we}), 0, o, f);
                end else if (o == 0) begin
                    chk("R1 alu", int'(alu_code), e_alu, o, f);
                end else begin
                    chk("R2 alu", int'(alu_code), e_alu, o, f);
                end
                chk("R3 src_imm", int'(src_imm), int'(imm_alu | ld | st), o, f);
                chk("R4 wb_mem", int'(wb_mem), int'(ld), o, f);
                chk("R5 dst_rt", int'(dst_rt), int'(imm_alu | ld), o, f);
                chk("R6 dst_link", int'(dst_link), int'(jal), o, f);
                chk("R7 wb_ret", int'(wb_ret), int'(jal | rt_jrl), o, f);
                chk("R8 npc", int'(npc_class), e_npc, o, f);
                chk("R9 br_inv", int'(br_inv), int'(bne), o, f);
                chk("R10 mem_wr", int'(mem_wr), int'(st), o, f);
                chk("R11 reg_we", int'(reg_we), int'(rt_alu | rt_jrl | imm_alu | ld | jal), o, f);
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule